// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block sits between an 8-bit CPU and everything it can address in a 64 KiB space. On each access it sorts the 16-bit address into one target region. The regions are cartridge space, video memory, external RAM, work RAM, object memory, I/O, high RAM, and a boot ROM that overlays the bottom of the cartridge space. The block raises one select line for an external target. It returns that target's byte, or a byte from one of its own registers, on the read data bus in the same cycle.

The block keeps five small pieces of state. The first is the boot-overlay latch. The second is the work-RAM bank register, which drives the upper bits of the physical work-RAM address. The third is the speed-switch armed flag. The fourth is the interrupt-enable byte. The fifth is a view of the interrupt-flag register, which is built from five pending bits held by the interrupt sources. The peripherals and memories stay outside the block. Each one qualifies its select with `cpu_wr` to form its write strobe.

Top module: `mem_route`

## Requirements
- R1: While the boot latch is set, reads of 0x0000-0x00FF select the boot ROM (dev_sel bit 7) and return boot_rdata, with boot_addr equal to the low 12 address bits. When ext_mode is 1, reads of 0x0200-0x08FF do the same. Every other access below 0x8000, including every write, selects the cartridge (dev_sel bit 0).
- R2: A write to 0xFF50 sets the boot latch when the data is zero and clears it otherwise. A read of 0xFF50 returns 0x00 while the latch is set and 0x01 once it is cleared.
- R3: Accesses to 0xC000-0xDFFF and 0xE000-0xFDFF select work RAM (dev_sel bit 3). For 0xC000-0xCFFF, wram_addr is the low 12 address bits. For 0xD000-0xDFFF, wram_addr is bank×0x1000 plus the low 12 bits.
- R4: A write to 0xFF70 keeps data bits 2:0 as the bank, and a value of 0 becomes 1. A read of 0xFF70 returns the bank in bits 2:0, with bits 7:3 set to one.
- R5: In 0xE000-0xFDFF, wram_addr is the address masked to its low 13 bits, whatever the bank.
- R6: 0xFEA0-0xFEFF selects no target and reads as 0xFF. I/O addresses in 0xFF00-0xFF7F that have no owner also read as 0xFF and select nothing.
- R7: A read of 0xFF0F returns irq_pend in bits 4:0, in the order vblank, status, timer, serial, joypad, with bits 7:5 set to one. A write to 0xFF0F pulses irq_wr in the same cycle, with irq_wdata equal to data bits 4:0.
- R8: A read of 0xFF4D returns the armed flag in bit 0, spd_double in bit 7 and ones in bits 6:1. A write to 0xFF4D loads the armed flag from data bit 0, and the flag is visible on spd_armed.
- R9: The remaining regions decode as follows. 0x8000-0x9FFF is video (bit 1), 0xA000-0xBFFF is external RAM (bit 2), 0xFE00-0xFE9F is object memory (bit 4) and 0xFF80-0xFFFE is high RAM (bit 6). I/O (bit 5) covers 0xFF00-0xFF02, 0xFF04-0xFF07, 0xFF10-0xFF26, 0xFF30-0xFF4B, 0xFF4F, 0xFF51-0xFF55 and 0xFF68-0xFF6B. 0xFFFF is an 8-bit interrupt-enable register that reads back what was last written to it.
- R10: dev_sel has at most one bit set, and only while cpu_rd or cpu_wr is high. cpu_rdata follows the address in the same cycle.
- R11: After reset, the boot latch is set, the bank is 1, the armed flag is 0 and the interrupt-enable byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | Extended mode, which enables the second boot window |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, same cycle |
| dev_sel | output | 8 | One-hot target select: cart, video, ext RAM, work RAM, object, I/O, high RAM, boot |
| boot_addr | output | 12 | Boot ROM byte address |
| wram_addr | output | 15 | Physical work-RAM address |
| cart_rdata | input | 8 | Cartridge read data |
| vram_rdata | input | 8 | Video memory read data |
| xram_rdata | input | 8 | External RAM read data |
| wram_rdata | input | 8 | Work RAM read data |
| oam_rdata | input | 8 | Object memory read data |
| io_rdata | input | 8 | I/O read data |
| hram_rdata | input | 8 | High RAM read data |
| boot_rdata | input | 8 | Boot ROM read data |
| irq_pend | input | 5 | Pending bits held by the interrupt sources |
| irq_wr | output | 1 | Interrupt-flag write pulse |
| irq_wdata | output | 5 | New pending bits for the sources |
| spd_double | input | 1 | Current speed (1 = double) |
| spd_armed | output | 1 | Speed-switch armed flag |

## Verification
Selects, addresses, irq_wr and read data are combinational. Each one is due 2 ns after the address or strobe changes, with no clock edge in between, and the address sweeps sample at that point. Register effects (boot latch, bank, armed flag, enable byte) land on the rising edge that closes a write. The bench drives writes at a falling edge and reads the result back only after the next falling edge. Each of the three full 64 Ki address sweeps runs with one register state held fixed, so every region check compares against a single known configuration.

// File: rtl/mem_route_pkg.sv
`timescale 1ns/1ps
package mem_route_pkg;

  // Codes 0..7 double as the dev_sel bit index of an external target.
  typedef enum logic [3:0] {
    RG_CART    = 4'd0,
    RG_VRAM    = 4'd1,
    RG_XRAM    = 4'd2,
    RG_WRAM    = 4'd3,
    RG_OAM     = 4'd4,
    RG_IO      = 4'd5,
    RG_HRAM    = 4'd6,
    RG_BOOT    = 4'd7,
    RG_VOID    = 4'd8,
    RG_IFLAG   = 4'd9,
    RG_SPEED   = 4'd10,
    RG_BOOTCTL = 4'd11,
    RG_BANK    = 4'd12,
    RG_IENABLE = 4'd13
  } region_t;

  localparam int EXT_TARGETS = 8;

  localparam logic [15:0] A_IFLAG   = 16'hFF0F;
  localparam logic [15:0] A_SPEED   = 16'hFF4D;
  localparam logic [15:0] A_BOOTCTL = 16'hFF50;
  localparam logic [15:0] A_BANK    = 16'hFF70;
  localparam logic [15:0] A_IENABLE = 16'hFFFF;

  // Low byte of an 0xFF00-0xFF7F address owned by an external peripheral.
  function automatic logic io_owned(input logic [7:0] lo);
    return (lo <= 8'h02) ||
           (lo >= 8'h04 && lo <= 8'h07) ||
           (lo >= 8'h10 && lo <= 8'h26) ||
           (lo >= 8'h30 && lo <= 8'h4B) ||
           (lo == 8'h4F) ||
           (lo >= 8'h51 && lo <= 8'h55) ||
           (lo >= 8'h68 && lo <= 8'h6B);
  endfunction

endpackage

// File: rtl/mem_route_decode.sv
`timescale 1ns/1ps
module mem_route_decode
  import mem_route_pkg::*;
#(
  parameter logic [15:0] BOOT_LO_END  = 16'h00FF,
  parameter logic [15:0] BOOT_HI_BASE = 16'h0200,
  parameter logic [15:0] BOOT_HI_END  = 16'h08FF
) (
  input  logic [15:0] addr,
  input  logic        is_wr,
  input  logic        boot_on,
  input  logic        ext_mode,
  output region_t     region
);

  logic in_boot;

  always_comb begin
    in_boot = boot_on && !is_wr &&
              ((addr <= BOOT_LO_END) ||
               (ext_mode && addr >= BOOT_HI_BASE && addr <= BOOT_HI_END));
  end

  always_comb begin
    region = RG_VOID;
    if (!addr[15])                region = in_boot ? RG_BOOT : RG_CART;
    else if (addr < 16'hA000)     region = RG_VRAM;
    else if (addr < 16'hC000)     region = RG_XRAM;
    else if (addr < 16'hFE00)     region = RG_WRAM;
    else if (addr < 16'hFEA0)     region = RG_OAM;
    else if (addr < 16'hFF00)     region = RG_VOID;
    else if (addr == A_IFLAG)     region = RG_IFLAG;
    else if (addr == A_SPEED)     region = RG_SPEED;
    else if (addr == A_BOOTCTL)   region = RG_BOOTCTL;
    else if (addr == A_BANK)      region = RG_BANK;
    else if (addr == A_IENABLE)   region = RG_IENABLE;
    else if (addr >= 16'hFF80)    region = RG_HRAM;
    else if (io_owned(addr[7:0])) region = RG_IO;
    else                          region = RG_VOID;
  end

endmodule

// File: rtl/mem_route_regs.sv
`timescale 1ns/1ps
module mem_route_regs
  import mem_route_pkg::*;
#(
  parameter int BANK_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  region_t              region,
  input  logic [7:0]           wdata,
  output logic                 boot_on,
  output logic [BANK_BITS-1:0] bank,
  output logic                 armed,
  output logic [7:0]           ie
);

  localparam logic [BANK_BITS-1:0] BANK_ONE = BANK_BITS'(1);

  logic [BANK_BITS-1:0] bank_req;
  assign bank_req = wdata[BANK_BITS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_on <= 1'b1;
      bank    <= BANK_ONE;
      armed   <= 1'b0;
      ie      <= 8'h00;
    end else if (wr_en) begin
      case (region)
        RG_BOOTCTL: boot_on <= (wdata == 8'h00);
        RG_BANK:    bank    <= (bank_req == '0) ? BANK_ONE : bank_req;
        RG_SPEED:   armed   <= wdata[0];
        RG_IENABLE: ie      <= wdata;
        default: ;
      endcase
    end
  end

  // R2
  boot_off_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && region == RG_BOOTCTL && wdata != 8'h00) |=> !boot_on);

  // R4
  bank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && region == RG_BANK && bank_req == '0) |=> (bank == BANK_ONE));

  // R8
  armed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && region == RG_SPEED) |=> (armed == $past(wdata[0])));

endmodule

// File: rtl/mem_route_wmap.sv
`timescale 1ns/1ps
module mem_route_wmap #(
  parameter int BANK_BITS = 3,
  parameter int PAGE_AW   = 12,
  localparam int WRAM_AW  = BANK_BITS + PAGE_AW
) (
  input  logic [15:0]          addr,
  input  logic [BANK_BITS-1:0] bank,
  output logic [WRAM_AW-1:0]   wram_addr
);

  localparam int MIRROR_AW = PAGE_AW + 1;

  always_comb begin
    if (addr[15:PAGE_AW] == 4'hD)
      wram_addr = {bank, addr[PAGE_AW-1:0]};
    else
      wram_addr = WRAM_AW'(addr[MIRROR_AW-1:0]);
  end

endmodule

// File: rtl/mem_route.sv
`timescale 1ns/1ps
module mem_route
  import mem_route_pkg::*;
#(
  parameter int BANK_BITS = 3,
  parameter int PAGE_AW   = 12,
  parameter int BOOT_AW   = 12,
  localparam int WRAM_AW  = BANK_BITS + PAGE_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_mode,
  input  logic [15:0]        cpu_addr,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [7:0]         cpu_wdata,
  output logic [7:0]         cpu_rdata,
  output logic [7:0]         dev_sel,
  output logic [BOOT_AW-1:0] boot_addr,
  output logic [WRAM_AW-1:0] wram_addr,
  input  logic [7:0]         cart_rdata,
  input  logic [7:0]         vram_rdata,
  input  logic [7:0]         xram_rdata,
  input  logic [7:0]         wram_rdata,
  input  logic [7:0]         oam_rdata,
  input  logic [7:0]         io_rdata,
  input  logic [7:0]         hram_rdata,
  input  logic [7:0]         boot_rdata,
  input  logic [4:0]         irq_pend,
  output logic               irq_wr,
  output logic [4:0]         irq_wdata,
  input  logic               spd_double,
  output logic               spd_armed
);

  region_t              region;
  logic                 boot_on;
  logic [BANK_BITS-1:0] bank;
  logic [7:0]           ie;
  logic                 access;

  assign access = cpu_rd | cpu_wr;

  mem_route_decode u_decode (
    .addr     (cpu_addr),
    .is_wr    (cpu_wr),
    .boot_on  (boot_on),
    .ext_mode (ext_mode),
    .region   (region)
  );

  mem_route_regs #(.BANK_BITS(BANK_BITS)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cpu_wr),
    .region  (region),
    .wdata   (cpu_wdata),
    .boot_on (boot_on),
    .bank    (bank),
    .armed   (spd_armed),
    .ie      (ie)
  );

  mem_route_wmap #(.BANK_BITS(BANK_BITS), .PAGE_AW(PAGE_AW)) u_wmap (
    .addr      (cpu_addr),
    .bank      (bank),
    .wram_addr (wram_addr)
  );

  for (genvar i = 0; i < EXT_TARGETS; i++) begin : g_sel
    assign dev_sel[i] = access && (region == region_t'(i));
  end

  assign boot_addr = cpu_addr[BOOT_AW-1:0];
  assign irq_wr    = cpu_wr && (region == RG_IFLAG);
  assign irq_wdata = cpu_wdata[4:0];

  always_comb begin
    case (region)
      RG_CART:    cpu_rdata = cart_rdata;
      RG_VRAM:    cpu_rdata = vram_rdata;
      RG_XRAM:    cpu_rdata = xram_rdata;
      RG_WRAM:    cpu_rdata = wram_rdata;
      RG_OAM:     cpu_rdata = oam_rdata;
      RG_IO:      cpu_rdata = io_rdata;
      RG_HRAM:    cpu_rdata = hram_rdata;
      RG_BOOT:    cpu_rdata = boot_rdata;
      RG_IFLAG:   cpu_rdata = {3'b111, irq_pend};
      RG_SPEED:   cpu_rdata = {spd_double, 6'h3F, spd_armed};
      RG_BOOTCTL: cpu_rdata = {7'h00, ~boot_on};
      RG_BANK:    cpu_rdata = {{(8-BANK_BITS){1'b1}}, bank};
      RG_IENABLE: cpu_rdata = ie;
      default:    cpu_rdata = 8'hFF;
    endcase
  end

  // R10
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_sel));

  // R10
  sel_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_sel != 8'h00) |-> access);

  // R6
  void_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr >= 16'hFEA0 && cpu_addr <= 16'hFEFF) |-> (cpu_rdata == 8'hFF && dev_sel == 8'h00));

  // R1
  boot_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_addr[15]) |-> (dev_sel == 8'h01));

endmodule

// File: tb/mem_route_tb.sv
`timescale 1ns/1ps
module mem_route_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_mode = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic [7:0]  dev_sel;
  logic [11:0] boot_addr;
  logic [14:0] wram_addr;
  logic [4:0]  irq_pend = 5'h00;
  logic        irq_wr;
  logic [4:0]  irq_wdata;
  logic        spd_double = 1'b0;
  logic        spd_armed;

  localparam logic [7:0] D_CART = 8'h11, D_VRAM = 8'h22, D_XRAM = 8'h33, D_WRAM = 8'h44;
  localparam logic [7:0] D_OAM = 8'h55, D_IO = 8'h66, D_HRAM = 8'h77, D_BOOT = 8'h88;

  always #10 clk = ~clk;

  mem_route u_dut (
    .clk(clk), .rst(rst), .ext_mode(ext_mode),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .dev_sel(dev_sel), .boot_addr(boot_addr), .wram_addr(wram_addr),
    .cart_rdata(D_CART), .vram_rdata(D_VRAM), .xram_rdata(D_XRAM), .wram_rdata(D_WRAM),
    .oam_rdata(D_OAM), .io_rdata(D_IO), .hram_rdata(D_HRAM), .boot_rdata(D_BOOT),
    .irq_pend(irq_pend), .irq_wr(irq_wr), .irq_wdata(irq_wdata),
    .spd_double(spd_double), .spd_armed(spd_armed)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Bench-side copy of the register state, computed from the requirements.
  bit       m_boot = 1'b1;
  int       m_bank = 1;
  bit       m_arm  = 1'b0;
  bit [7:0] m_ie   = 8'h00;

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic bit owned_io(input int lo);
    return (lo <= 2) || (lo >= 4 && lo <= 7) || (lo >= 'h10 && lo <= 'h26) ||
           (lo >= 'h30 && lo <= 'h4B) || (lo == 'h4F) || (lo >= 'h51 && lo <= 'h55) ||
           (lo >= 'h68 && lo <= 'h6B);
  endfunction

  // Expected select index: 0..7 external target, -1 none.
  function automatic int exp_target(input int a);
    if (a < 'h8000) begin
      if (m_boot && (a <= 'hFF || (ext_mode && a >= 'h200 && a <= 'h8FF))) return 7;
      return 0;
    end
    if (a < 'hA000) return 1;
    if (a < 'hC000) return 2;
    if (a < 'hFE00) return 3;
    if (a < 'hFEA0) return 4;
    if (a < 'hFF00) return -1;
    if (a >= 'hFF80 && a != 'hFFFF) return 6;
    if (a == 'hFF0F || a == 'hFF4D || a == 'hFF50 || a == 'hFF70 || a == 'hFFFF) return -1;
    if (owned_io(a & 'hFF)) return 5;
    return -1;
  endfunction

  function automatic int exp_data(input int a);
    int t;
    t = exp_target(a);
    case (t)
      0: return D_CART;  1: return D_VRAM;  2: return D_XRAM;  3: return D_WRAM;
      4: return D_OAM;   5: return D_IO;    6: return D_HRAM;  7: return D_BOOT;
      default: ;
    endcase
    if (a == 'hFF0F) return 'hE0 + irq_pend;
    if (a == 'hFF4D) return (spd_double ? 'h80 : 0) + 'h7E + (m_arm ? 1 : 0);
    if (a == 'hFF50) return m_boot ? 0 : 1;
    if (a == 'hFF70) return 'hF8 + m_bank;
    if (a == 'hFFFF) return m_ie;
    return 'hFF;
  endfunction

  function automatic int exp_wram(input int a);
    if (a >= 'hD000 && a < 'hE000) return m_bank * 'h1000 + (a % 'h1000);
    return a % 'h2000;
  endfunction

  task automatic sweep(input string tag);
    cpu_rd = 1'b1;
    for (int a = 0; a < 65536; a++) begin
      int t;
      int ed;
      bit ok;
      cpu_addr = 16'(a);
      #2;
      t  = exp_target(a);
      ed = exp_data(a);
      ok = (int'(cpu_rdata) == ed) && (dev_sel == ((t < 0) ? 8'h00 : 8'(1 << t)));
      if (t == 3) ok = ok && (int'(wram_addr) == exp_wram(a));
      if (t == 7) ok = ok && (int'(boot_addr) == (a % 'h1000));
      // R1 R3 R5 R6 R7 R9 region sweep
      if (!ok) begin
        $display("FAIL R9 sweep %s addr %h: data %h sel %h wram %h", tag, a[15:0], cpu_rdata, dev_sel, wram_addr);
        check(1'b0, "R1/R3/R5/R6/R9 sweep", int'(cpu_rdata), ed);
      end else begin
        n_run++;
      end
    end
    cpu_rd = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [15:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #2;
    check(cpu_rdata == e, req, int'(cpu_rdata), int'(e));
    cpu_rd = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    rd_check(16'hFF50, 8'h00, "R11 boot latch set");
    rd_check(16'hFF70, 8'hF9, "R11 bank 1");
    rd_check(16'hFF4D, 8'h7E, "R11 armed clear");
    rd_check(16'hFFFF, 8'h00, "R11 ie zero");

    // R10 no select while idle
    cpu_addr = 16'hC123; #2;
    check(dev_sel == 8'h00, "R10 idle select", int'(dev_sel), 0);

    // R1 writes into the boot window go to the cartridge
    @(negedge clk);
    cpu_addr = 16'h0010; cpu_wdata = 8'h5A; cpu_wr = 1'b1; #2;
    check(dev_sel == 8'h01, "R1 write to cart", int'(dev_sel), 1);
    @(negedge clk); cpu_wr = 1'b0;

    // R6 writes to the unusable hole select nothing
    @(negedge clk);
    cpu_addr = 16'hFEC0; cpu_wdata = 8'h12; cpu_wr = 1'b1; #2;
    check(dev_sel == 8'h00, "R6 hole write", int'(dev_sel), 0);
    @(negedge clk); cpu_wr = 1'b0;
    rd_check(16'hFEC0, 8'hFF, "R6 hole read after write");

    // R7 interrupt flag write pulse
    @(negedge clk);
    cpu_addr = 16'hFF0F; cpu_wdata = 8'hF5; cpu_wr = 1'b1; #2;
    check(irq_wr && irq_wdata == 5'h15, "R7 flag write", {irq_wr, irq_wdata}, 'h35);
    @(negedge clk); cpu_wr = 1'b0; #2;
    check(!irq_wr, "R7 pulse ends", int'(irq_wr), 0);

    // Sweep 1: boot on, extended mode, bank 1
    irq_pend = 5'h0A;
    sweep("boot-ext");
    // Sweep 2: boot on, base mode
    ext_mode = 1'b0;
    sweep("boot-base");

    // R4 bank writes
    wr(16'hFF70, 8'hF8); m_bank = 1;
    rd_check(16'hFF70, 8'hF9, "R4 bank zero maps to 1");
    wr(16'hFF70, 8'h0D); m_bank = 5;
    rd_check(16'hFF70, 8'hFD, "R4 bank low bits");

    // R2 boot latch
    wr(16'hFF50, 8'h00);
    rd_check(16'hFF50, 8'h00, "R2 zero write keeps overlay");
    wr(16'hFF50, 8'h40); m_boot = 1'b0;
    rd_check(16'hFF50, 8'h01, "R2 nonzero disables overlay");
    rd_check(16'h0020, D_CART, "R2 low page now cartridge");

    // R8 speed
    wr(16'hFF4D, 8'hFF); m_arm = 1'b1;
    #2;
    check(spd_armed == 1'b1, "R8 armed output", int'(spd_armed), 1);
    spd_double = 1'b1;
    rd_check(16'hFF4D, 8'hFF, "R8 speed read");
    wr(16'hFF4D, 8'h02); m_arm = 1'b0;
    rd_check(16'hFF4D, 8'hFE, "R8 armed cleared by bit 0");
    wr(16'hFF4D, 8'h01); m_arm = 1'b1;

    // R9 interrupt enable
    wr(16'hFFFF, 8'hA5); m_ie = 8'hA5;
    rd_check(16'hFFFF, 8'hA5, "R9 ie readback");

    // Sweep 3: boot off, extended mode, bank 5, new state
    ext_mode = 1'b1;
    irq_pend = 5'h1F;
    sweep("boot-off");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule